// File: doc/BRIEF.md
# SPI Byte-Addressed Serial Memory Slave

This block is the device end of a byte-wide nonvolatile serial memory reached over an SPI link. Each transfer opens with chip select falling and an eight-bit command. Reads and writes then carry a big-endian 16-bit address followed by any number of data bytes. An internal address counter moves one location per byte, so a single transfer can stream through the whole address space. A small status byte holds a protect-enable bit and a two-bit block-protect field, and the live write-enable latch can be read through it.

All SPI pins are brought into the block's own clock domain through synchronizer chains. SCK edges are then found as single-cycle events, so the serial clock must be well below the system clock; the bench uses 16 system clocks per SCK period. A hold input pauses a transfer in the middle of a byte without deselecting it. A write-protect pin, together with the protect-enable bit, locks the status byte. The 16-bit address space is folded onto a storage array of `2**STORE_AW` bytes; the array is 64K bytes when `STORE_AW` = 16.

Top module: `spi_mem_slave`

## Requirements
- R1: Clock modes 0 and 3 both work. SDI is taken on the rising SCK edge, and SDO changes on the falling SCK edge, MSB first.
- R2: While chip select is high, `spi_miso_oe` is 0 and SCK/SDI activity changes no state.
- R3: Command codes: 0x06 set write latch, 0x04 clear write latch, 0x05 read status, 0x01 write status, 0x03 read array, 0x02 write array. Any other first byte makes the rest of the transfer ignored until chip select rises.
- R4: The write latch (status bit 1) sets at the end of a 0x06 byte and clears at the end of a 0x04 byte. It also clears when chip select rises after a 0x02 or 0x01 transfer.
- R5: Read array: the command is followed by a 16-bit address, high byte first. Data then shifts out from that address, and the address rises by one after each byte.
- R6: Write array stores each complete data byte at the counter address, and the address then rises by one. Nothing is stored while the write latch is 0.
- R7: The address counter wraps from 0xFFFF to 0x0000.
- R8: A data byte cut short by chip select rising before its eighth bit is discarded.
- R9: While hold is low with chip select low, `spi_miso_oe` is 0 and SCK edges are ignored. The transfer resumes at the same bit when hold returns high.
- R10: The status byte is {protect-enable, 0, 0, 0, bp[1], bp[0], write latch, 0}. A write-status transfer with the latch set updates only bits 7, 3 and 2.
- R11: A status write is refused while the write-protect pin is low and protect-enable is 1.
- R12: Block-protect field: 00 locks nothing, 01 locks 0xC000-0xFFFF, 10 locks 0x8000-0xFFFF, 11 locks all addresses. Array writes to locked addresses are dropped.
- R13: After reset the status byte reads 0x00 and `spi_miso_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data into the device |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_wp_n | input | 1 | Status write protect, active low |
| spi_miso | output | 1 | Serial data out of the device |
| spi_miso_oe | output | 1 | Output enable for the SDO pad |

## Verification
Each pin change takes effect on the third system clock edge after it, because it passes two synchronizer stages and an edge register. SDO therefore settles three clocks after an SCK fall, and the bench reads it eight clocks after that fall, just before it raises SCK. Status-register and latch effects are checked through a later read-status transfer. Array writes are checked by a later read, so no result is sampled inside the three-clock settling window. The hold check waits eight clocks after hold goes low before reading the enable.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam logic [7:0] CMD_WEN_SET = 8'h06;
  localparam logic [7:0] CMD_WEN_CLR = 8'h04;
  localparam logic [7:0] CMD_SR_RD   = 8'h05;
  localparam logic [7:0] CMD_SR_WR   = 8'h01;
  localparam logic [7:0] CMD_MEM_RD  = 8'h03;
  localparam logic [7:0] CMD_MEM_WR  = 8'h02;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_RDAT,
    PH_WDAT,
    PH_SRRD,
    PH_SRWR,
    PH_SKIP
  } phase_e;

  typedef struct packed {
    logic       lock_en;
    logic [1:0] bp;
  } sr_cfg_t;

  // Two top address bits decide the locked range for each bp code.
  function automatic logic region_locked(input logic [1:0] top2, input logic [1:0] bp);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic sr_frozen(input logic lock_en, input logic wp_n);
    return lock_en & ~wp_n;
  endfunction

  function automatic logic [7:0] sr_image(input sr_cfg_t c, input logic wel);
    return {c.lock_en, 3'b000, c.bp, wel, 1'b0};
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic sel,
  output logic hold_act,
  output logic si_s,
  output logic wp_n_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic desel_evt
);
  localparam int NSIG = 5;
  localparam logic [NSIG-1:0] RST_VAL = 5'b10011;

  logic [STAGES-1:0][NSIG-1:0] stage_q;
  logic [NSIG-1:0] raw, synced;
  logic sck_prev_q, cs_n_prev_q;

  assign raw    = {cs_n, sck, si, hold_n, wp_n};
  assign synced = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q     <= {STAGES{RST_VAL}};
      sck_prev_q  <= 1'b0;
      cs_n_prev_q <= 1'b1;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) stage_q[i] <= stage_q[i-1];
      stage_q[0]  <= raw;
      sck_prev_q  <= synced[3];
      cs_n_prev_q <= synced[4];
    end
  end

  assign sel       = ~synced[4];
  assign si_s      = synced[2];
  assign hold_act  = ~synced[1];
  assign wp_n_s    = synced[0];
  assign sck_rise  = synced[3] & ~sck_prev_q;
  assign sck_fall  = ~synced[3] & sck_prev_q;
  assign desel_evt = synced[4] & ~cs_n_prev_q;

endmodule

// File: rtl/spi_status_reg.sv
module spi_status_reg import spi_mem_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wel_set,
  input  logic       wel_clr,
  input  logic       sr_we,
  input  logic [7:0] sr_wdata,
  input  logic       wp_n_s,
  output sr_cfg_t    cfg,
  output logic       wel,
  output logic       sr_commit,
  output logic [7:0] sr_byte
);
  assign sr_commit = sr_we & ~sr_frozen(cfg.lock_en, wp_n_s);
  assign sr_byte   = sr_image(cfg, wel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
      wel <= 1'b0;
    end else begin
      if (sr_commit) begin
        cfg.lock_en <= sr_wdata[7];
        cfg.bp      <= sr_wdata[3:2];
      end
      if (wel_clr)      wel <= 1'b0;
      else if (wel_set) wel <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_store.sv
module spi_store #(
  parameter int STORE_AW = 10
) (
  input  logic                clk,
  input  logic                we,
  input  logic [STORE_AW-1:0] addr,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata
);
  localparam int DEPTH = 1 << STORE_AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine import spi_mem_pkg::*; #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              hold_act,
  input  logic              si_s,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              desel_evt,
  input  logic              wel,
  input  logic [1:0]        bp,
  input  logic [7:0]        sr_byte,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] addr_q,
  output logic              mem_we,
  output logic              sr_we,
  output logic [7:0]        rx_byte,
  output logic              wel_set,
  output logic              wel_clr,
  output logic              byte_done,
  output logic              addr_step_evt,
  output logic              tx_bit,
  output logic              tx_en
);
  localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
  localparam int ABC_W      = $clog2(ADDR_BYTES + 1);
  localparam logic [ABC_W-1:0] LAST_ABYTE = ABC_W'(ADDR_BYTES - 1);

  phase_e           ph_q;
  logic [2:0]       bit_q;
  logic [6:0]       rx_q;
  logic [ABC_W-1:0] abyte_q;
  logic             is_write_q;
  logic             wr_cmd_q;
  logic             load_q;
  logic [7:0]       tx_q;
  logic             rise_ok, fall_ok;
  logic             rd_phase;

  assign rise_ok   = sel & ~hold_act & sck_rise;
  assign fall_ok   = sel & ~hold_act & sck_fall;
  assign byte_done = rise_ok && (bit_q == 3'd7);
  assign rx_byte   = {rx_q, si_s};
  assign tx_bit    = tx_q[7];
  assign rd_phase  = (ph_q == PH_RDAT) || (ph_q == PH_SRRD);

  always_comb begin
    mem_we        = byte_done && (ph_q == PH_WDAT) && wel &&
                    !region_locked(addr_q[ADDR_W-1 -: 2], bp);
    sr_we         = byte_done && (ph_q == PH_SRWR) && wel;
    wel_set       = byte_done && (ph_q == PH_CMD) && (rx_byte == CMD_WEN_SET);
    wel_clr       = (byte_done && (ph_q == PH_CMD) && (rx_byte == CMD_WEN_CLR)) ||
                    (desel_evt && wr_cmd_q);
    addr_step_evt = byte_done && ((ph_q == PH_RDAT) || (ph_q == PH_WDAT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_CMD;
      bit_q      <= '0;
      rx_q       <= '0;
      abyte_q    <= '0;
      is_write_q <= 1'b0;
      wr_cmd_q   <= 1'b0;
      load_q     <= 1'b0;
      tx_q       <= '0;
      tx_en      <= 1'b0;
      addr_q     <= '0;
    end else if (!sel) begin
      ph_q     <= PH_CMD;
      bit_q    <= '0;
      abyte_q  <= '0;
      wr_cmd_q <= 1'b0;
      load_q   <= 1'b0;
      tx_en    <= 1'b0;
    end else begin
      if (rise_ok) begin
        bit_q <= bit_q + 3'd1;
        rx_q  <= {rx_q[5:0], si_s};
      end
      if (byte_done) begin
        load_q <= 1'b1;
        case (ph_q)
          PH_CMD: begin
            case (rx_byte)
              CMD_MEM_RD: begin ph_q <= PH_ADDR; is_write_q <= 1'b0; end
              CMD_MEM_WR: begin ph_q <= PH_ADDR; is_write_q <= 1'b1; wr_cmd_q <= 1'b1; end
              CMD_SR_RD:  ph_q <= PH_SRRD;
              CMD_SR_WR:  begin ph_q <= PH_SRWR; wr_cmd_q <= 1'b1; end
              default:    ph_q <= PH_SKIP;
            endcase
          end
          PH_ADDR: begin
            addr_q <= {addr_q[ADDR_W-9:0], rx_byte};
            if (abyte_q == LAST_ABYTE) begin
              abyte_q <= '0;
              ph_q    <= is_write_q ? PH_WDAT : PH_RDAT;
            end else begin
              abyte_q <= abyte_q + ABC_W'(1);
            end
          end
          PH_RDAT, PH_WDAT: addr_q <= addr_q + ADDR_W'(1);
          default: ;
        endcase
      end
      if (fall_ok) begin
        if (load_q) begin
          load_q <= 1'b0;
          tx_q   <= (ph_q == PH_SRRD) ? sr_byte : rd_data;
          tx_en  <= rd_phase;
        end else begin
          tx_q <= {tx_q[6:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave import spi_mem_pkg::*; #(
  parameter int ADDR_W      = 16,
  parameter int STORE_AW    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  input  logic spi_hold_n,
  input  logic spi_wp_n,
  output logic spi_miso,
  output logic spi_miso_oe
);
  logic              sel, hold_act, si_s, wp_n_s;
  logic              sck_rise, sck_fall, desel_evt;
  logic [ADDR_W-1:0] addr_q;
  logic              mem_we, sr_we, sr_commit;
  logic              wel, wel_set, wel_clr;
  logic              byte_done, addr_step_evt, tx_en;
  logic [7:0]        rx_byte, rd_data, sr_byte;
  sr_cfg_t           cfg;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .cs_n(spi_cs_n), .sck(spi_sck), .si(spi_mosi),
    .hold_n(spi_hold_n), .wp_n(spi_wp_n),
    .sel(sel), .hold_act(hold_act), .si_s(si_s), .wp_n_s(wp_n_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .desel_evt(desel_evt)
  );

  spi_cmd_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .sel(sel), .hold_act(hold_act), .si_s(si_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .desel_evt(desel_evt),
    .wel(wel), .bp(cfg.bp), .sr_byte(sr_byte), .rd_data(rd_data),
    .addr_q(addr_q), .mem_we(mem_we), .sr_we(sr_we), .rx_byte(rx_byte),
    .wel_set(wel_set), .wel_clr(wel_clr), .byte_done(byte_done),
    .addr_step_evt(addr_step_evt), .tx_bit(spi_miso), .tx_en(tx_en)
  );

  spi_status_reg u_sr (
    .clk(clk), .rst_n(rst_n),
    .wel_set(wel_set), .wel_clr(wel_clr),
    .sr_we(sr_we), .sr_wdata(rx_byte), .wp_n_s(wp_n_s),
    .cfg(cfg), .wel(wel), .sr_commit(sr_commit), .sr_byte(sr_byte)
  );

  spi_store #(.STORE_AW(STORE_AW)) u_mem (
    .clk(clk), .we(mem_we), .addr(addr_q[STORE_AW-1:0]),
    .wdata(rx_byte), .rdata(rd_data)
  );

  assign spi_miso_oe = sel & ~hold_act & tx_en;

endmodule

// File: rtl/spi_mem_sva.sv
module spi_mem_sva #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              spi_hold_n,
  input logic              spi_miso_oe,
  input logic              mem_we,
  input logic              sr_we,
  input logic              sr_commit,
  input logic              wel,
  input logic              wel_set,
  input logic              lock_en,
  input logic [1:0]        bp,
  input logic              wp_n_s,
  input logic              addr_step_evt,
  input logic [ADDR_W-1:0] addr_q,
  input logic              byte_done
);

  // R2
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |-> !spi_miso_oe);

  // R9
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_hold_n && !$past(spi_hold_n) && !$past(spi_hold_n, 2)) |-> !spi_miso_oe);

  // R6
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wel);

  // R6
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, sr_we}) && (!(mem_we || sr_we) || byte_done));

  // R4
  wel_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(wel_set));

  // R12
  full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (bp != 2'b11));

  // R11
  sr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_en && !wp_n_s) |=> $stable({lock_en, bp}));

  // R10
  sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_commit |=> $stable({lock_en, bp}));

  // R7
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_step_evt && (addr_q == '1)) |=> (addr_q == '0));

endmodule

bind spi_mem_slave spi_mem_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n),
  .spi_cs_n(spi_cs_n), .spi_hold_n(spi_hold_n), .spi_miso_oe(spi_miso_oe),
  .mem_we(mem_we), .sr_we(sr_we), .sr_commit(sr_commit),
  .wel(wel), .wel_set(wel_set),
  .lock_en(cfg.lock_en), .bp(cfg.bp), .wp_n_s(wp_n_s),
  .addr_step_evt(addr_step_evt), .addr_q(addr_q), .byte_done(byte_done)
);

// File: tb/sim_spi_mem_slave.sv
module sim_spi_mem_slave;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic spi_hold_n = 1'b1, spi_wp_n = 1'b1;
  logic spi_miso, spi_miso_oe;
  logic cpol = 1'b0;
  int   n_checks = 0, n_errors = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  spi_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_hold_n(spi_hold_n), .spi_wp_n(spi_wp_n),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic begin_xfer();
    spi_sck = cpol; wait_clk(HALF);
    spi_cs_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic end_xfer();
    spi_sck = cpol; wait_clk(HALF);
    spi_cs_n = 1'b1; wait_clk(2 * HALF);
  endtask

  task automatic shift_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_sck = 1'b0; spi_mosi = tx[i]; wait_clk(HALF);
      rx[i] = spi_miso;
      spi_sck = 1'b1; wait_clk(HALF);
    end
  endtask

  task automatic shift_byte(input logic [7:0] tx, output logic [7:0] rx);
    shift_bits(tx, 8, rx);
  endtask

  task automatic one_cmd(input logic [7:0] op);
    logic [7:0] d;
    begin_xfer(); shift_byte(op, d); end_xfer();
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] d;
    begin_xfer(); shift_byte(8'h05, d); shift_byte(8'h00, s); end_xfer();
  endtask

  task automatic wr_status(input logic [7:0] v);
    logic [7:0] d;
    begin_xfer(); shift_byte(8'h01, d); shift_byte(v, d); end_xfer();
  endtask

  task automatic send_addr(input logic [7:0] op, input logic [15:0] a);
    logic [7:0] d;
    shift_byte(op, d); shift_byte(a[15:8], d); shift_byte(a[7:0], d);
  endtask

  task automatic mem_write(input logic [15:0] a, input logic [31:0] data, input int n);
    logic [7:0] d;
    begin_xfer(); send_addr(8'h02, a);
    for (int k = 0; k < n; k++) shift_byte(data[31-8*k -: 8], d);
    end_xfer();
  endtask

  task automatic mem_read(input logic [15:0] a, input int n, output logic [31:0] data);
    logic [7:0] d;
    data = '0;
    begin_xfer(); send_addr(8'h03, a);
    for (int k = 0; k < n; k++) begin
      shift_byte(8'h00, d); data[31-8*k -: 8] = d;
    end
    end_xfer();
  endtask

  task automatic t_reset();
    logic [7:0] s;
    check("R13 oe after reset", {31'd0, spi_miso_oe}, 32'd0);
    rd_status(s);
    check("R13 status after reset", {24'd0, s}, 32'h00);
  endtask

  task automatic t_wel();
    logic [7:0] s;
    one_cmd(8'h06); rd_status(s);
    check("R4 latch set", {24'd0, s}, 32'h02);
    one_cmd(8'h04); rd_status(s);
    check("R4 latch cleared", {24'd0, s}, 32'h00);
  endtask

  task automatic t_rw_mode0();
    logic [31:0] d; logic [7:0] s;
    one_cmd(8'h06); mem_write(16'h0100, 32'hA55A3C00, 3);
    rd_status(s);
    check("R4 latch cleared after write", {24'd0, s}, 32'h00);
    mem_read(16'h0100, 3, d);
    check("R5 R6 stream mode0", d, 32'hA55A3C00);
    mem_read(16'h0101, 1, d);
    check("R5 start mid-range", d, 32'h5A000000);
  endtask

  task automatic t_mode3();
    logic [31:0] d;
    cpol = 1'b1;
    one_cmd(8'h06); mem_write(16'h0200, 32'h11000000, 1);
    mem_read(16'h0200, 1, d);
    check("R1 mode3 write/read", d, 32'h11000000);
    mem_read(16'h0100, 2, d);
    check("R1 mode3 stream", d, 32'hA55A0000);
    cpol = 1'b0;
  endtask

  task automatic t_no_wel();
    logic [31:0] d;
    mem_write(16'h0200, 32'h77000000, 1);
    mem_read(16'h0200, 1, d);
    check("R6 write without latch", d, 32'h11000000);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    one_cmd(8'h06); mem_write(16'hFFFF, 32'hABCD0000, 2);
    mem_read(16'hFFFF, 2, d);
    check("R7 wrap read", d, 32'hABCD0000);
    mem_read(16'h0000, 1, d);
    check("R7 wrap landed at 0", d, 32'hCD000000);
  endtask

  task automatic t_partial();
    logic [31:0] d; logic [7:0] r;
    one_cmd(8'h06); mem_write(16'h0301, 32'h22000000, 1);
    one_cmd(8'h06);
    begin_xfer(); send_addr(8'h02, 16'h0300);
    shift_byte(8'h99, r); shift_bits(8'h5F, 4, r);
    end_xfer();
    mem_read(16'h0300, 2, d);
    check("R8 partial byte dropped", d, 32'h99220000);
  endtask

  task automatic t_unknown();
    logic [31:0] d; logic [7:0] r, s;
    one_cmd(8'h06); mem_write(16'h0120, 32'h31000000, 1);
    one_cmd(8'h06);
    begin_xfer();
    shift_byte(8'hFF, r); shift_byte(8'h02, r); shift_byte(8'h01, r);
    shift_byte(8'h20, r); shift_byte(8'hEE, r);
    end_xfer();
    mem_read(16'h0120, 1, d);
    check("R3 unknown command ignored", d, 32'h31000000);
    rd_status(s);
    check("R3 latch untouched", {24'd0, s}, 32'h02);
    one_cmd(8'h04);
  endtask

  task automatic t_cs_high();
    logic [7:0] s;
    int bad = 0;
    one_cmd(8'h06);
    for (int k = 0; k < 16; k++) begin
      spi_mosi = k[0]; spi_sck = 1'b0; wait_clk(HALF);
      if (spi_miso_oe !== 1'b0) bad++;
      spi_mosi = k[1]; spi_sck = 1'b1; wait_clk(HALF);
    end
    spi_sck = 1'b0; wait_clk(HALF);
    check("R2 oe while deselected", bad, 0);
    rd_status(s);
    check("R2 no state change", {24'd0, s}, 32'h02);
    one_cmd(8'h04);
  endtask

  task automatic t_hold();
    logic [7:0] r, b0, b1;
    begin_xfer(); send_addr(8'h03, 16'h0100);
    shift_byte(8'h00, b0);
    for (int i = 7; i >= 0; i--) begin
      if (i == 3) begin
        spi_hold_n = 1'b0; wait_clk(HALF);
        check("R9 oe low in hold", {31'd0, spi_miso_oe}, 32'd0);
        for (int k = 0; k < 3; k++) begin
          spi_sck = 1'b0; spi_mosi = 1'b1; wait_clk(HALF);
          spi_sck = 1'b1; wait_clk(HALF);
        end
        spi_hold_n = 1'b1; wait_clk(HALF);
      end
      spi_sck = 1'b0; wait_clk(HALF);
      b1[i] = spi_miso;
      spi_sck = 1'b1; wait_clk(HALF);
    end
    shift_byte(8'h00, r);
    end_xfer();
    check("R9 byte before hold", {24'd0, b0}, 32'hA5);
    check("R9 resumed byte", {24'd0, b1}, 32'h5A);
    check("R9 stream continues", {24'd0, r}, 32'h3C);
  endtask

  task automatic t_status();
    logic [7:0] s;
    one_cmd(8'h06); wr_status(8'hFF); rd_status(s);
    check("R10 writable bits only", {24'd0, s}, 32'h8C);
    wr_status(8'h00); rd_status(s);
    check("R10 no write without latch", {24'd0, s}, 32'h8C);
  endtask

  task automatic t_wp();
    logic [7:0] s;
    spi_wp_n = 1'b0;
    one_cmd(8'h06); wr_status(8'h00); rd_status(s);
    check("R11 status locked", {24'd0, s}, 32'h8C);
    spi_wp_n = 1'b1;
    one_cmd(8'h06); wr_status(8'h00); rd_status(s);
    check("R11 unlocked by pin", {24'd0, s}, 32'h00);
    spi_wp_n = 1'b0;
    one_cmd(8'h06); wr_status(8'h08); rd_status(s);
    check("R11 pin alone does not lock", {24'd0, s}, 32'h08);
    spi_wp_n = 1'b1;
  endtask

  task automatic t_bp();
    logic [31:0] d;
    one_cmd(8'h06); wr_status(8'h00);
    one_cmd(8'h06); mem_write(16'hC123, 32'h5E000000, 1);
    one_cmd(8'h06); mem_write(16'h0040, 32'h21000000, 1);
    one_cmd(8'h06); wr_status(8'h04);
    one_cmd(8'h06); mem_write(16'hC123, 32'h99000000, 1);
    mem_read(16'hC123, 1, d);
    check("R12 upper quarter locked", d, 32'h5E000000);
    one_cmd(8'h06); mem_write(16'hBFF0, 32'h44000000, 1);
    mem_read(16'hBFF0, 1, d);
    check("R12 below quarter open", d, 32'h44000000);
    one_cmd(8'h06); wr_status(8'h08);
    one_cmd(8'h06); mem_write(16'hBFF0, 32'h45000000, 1);
    mem_read(16'hBFF0, 1, d);
    check("R12 upper half locked", d, 32'h44000000);
    one_cmd(8'h06); wr_status(8'h0C);
    one_cmd(8'h06); mem_write(16'h0040, 32'h12000000, 1);
    mem_read(16'h0040, 1, d);
    check("R12 all locked", d, 32'h21000000);
    one_cmd(8'h06); wr_status(8'h00);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_wel();
    t_rw_mode0();
    t_mode3();
    t_no_wel();
    t_wrap();
    t_partial();
    t_unknown();
    t_cs_high();
    t_hold();
    t_status();
    t_wp();
    t_bp();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule